// File: doc/BRIEF.md
# Switch tag inserter

This block sits on the byte-wide frame path from a host processor toward an Ethernet switch fabric. It places a 4-byte switch tag right after the 12 address bytes of every frame. The tag tells the switch which egress port the frame is meant for, and whether an 802.1Q header follows. Streams use valid/ready handshakes with a last-byte marker. Two sideband inputs come with each frame: a destination port index and a hint that says whether the sender believes the frame carries a VLAN tag.

The inserter reads bytes 12 and 13 to decide the frame type itself. It does not trust the hint for this. On an untagged frame it adds four bytes, so the frame grows by four. On a frame with TPID 0x8100 it writes the first two tag bytes over the TPID. The two bytes that follow are the original tag control information and pass through unchanged, so the length stays the same. The switch can then read the switch tag and the VLAN identifier as one header. When the hint disagrees with what was detected, a one-cycle error pulse is raised. The frame is still built from the detected value.

Top module: `stsi_tag_inserter`

## Requirements
- R1: Output bytes 0 to 11 of every frame of 14 bytes or more equal input bytes 0 to 11, in order.
- R2: A frame whose bytes 12 and 13 are 0x81 and 0x00 is tagged. Its output byte 12 is 0x01 and output byte 13 is the port mask. Input bytes 14 onward follow unchanged, so the output length equals the input length.
- R3: Any other frame of 14 bytes or more is untagged. Its output bytes 12 to 15 are 0x00, the port mask, 0x00 and 0x00. Input bytes 12 onward follow, so the output is 4 bytes longer.
- R4: The port mask is 1 shifted left by `dst_port` when `dst_port` is below 6, and 0x00 for 6 and 7. `dst_port` is sampled with the first byte of the frame.
- R5: `vlan_hint` is sampled with the first byte. `hint_err` is high for exactly one cycle, the cycle after byte 13 is accepted, when the hint differs from the detected type. It is never high otherwise.
- R6: With `m_tready` held high, `s_tready` is low for 6 cycles in each untagged frame and 2 cycles in each tagged frame, while the generated and held bytes are sent.
- R7: `m_tlast` is high on the final output byte of each frame and on no other byte.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tlast` and `m_tvalid` stay unchanged and `s_tready` is low.
- R9: The first byte of the next frame can be accepted in the cycle right after the last byte of the previous frame.
- R10: A frame shorter than 14 bytes passes through unchanged, and no error pulse is raised for it.
- R11: During and right after reset, `m_tvalid` and `hint_err` are low and `s_tready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 8 | Input frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted when high with valid |
| s_tlast | input | 1 | Input byte is the last of the frame |
| dst_port | input | PORT_W (3) | Destination port index, read on the first byte |
| vlan_hint | input | 1 | Sender's claim that the frame is VLAN tagged |
| m_tdata | output | 8 | Output frame byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream accepts the output byte |
| m_tlast | output | 1 | Output byte is the last of the frame |
| hint_err | output | 1 | One-cycle pulse when the hint and the detected type differ |

## Verification
A wrong sequencer state shows up within the first 16 output bytes of a frame. The tag bytes land in the wrong place or carry the wrong values, the output length is off by two or four, or `m_tlast` marks the wrong byte. A stale held byte or a missed stall appears as a changed `m_tdata` during backpressure, in the very next cycle. A wrong count of input stall cycles at full rate shows that the insertion sequence has too many or too few steps. An error pulse that is missing, doubled or out of place is counted against the frames whose hint was set wrong on purpose.

// File: rtl/stsi_pkg.sv
package stsi_pkg;

    localparam int unsigned STSI_ADDR_LEN = 12;
    localparam int unsigned STSI_CNT_W    = $clog2(STSI_ADDR_LEN + 1);
    localparam int unsigned STSI_BYTE_W   = 8;

    typedef enum logic [3:0] {
        S_ADDR  = 4'd0,
        S_HOLD0 = 4'd1,
        S_HOLD1 = 4'd2,
        S_TAG0  = 4'd3,
        S_TAG1  = 4'd4,
        S_TAG2  = 4'd5,
        S_TAG3  = 4'd6,
        S_ET0   = 4'd7,
        S_ET1   = 4'd8,
        S_BODY  = 4'd9
    } seq_state_e;

    typedef struct packed {
        seq_state_e             st;
        logic [STSI_CNT_W-1:0]  cnt;
        logic [STSI_BYTE_W-1:0] hold_hi;
        logic [STSI_BYTE_W-1:0] hold_lo;
        logic                   hold_last;
        logic                   is_vlan;
        logic                   hint;
        logic [STSI_BYTE_W-1:0] mask;
        logic                   ovalid;
        logic [STSI_BYTE_W-1:0] odata;
        logic                   olast;
        logic                   herr;
    } seq_regs_t;

endpackage

// File: rtl/stsi_portmask.sv
module stsi_portmask #(
    parameter int unsigned PORT_W = 3,
    parameter int unsigned MASK_W = 6,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [PORT_W-1:0] port_idx,
    output logic [BYTE_W-1:0] port_mask
);

    // One-hot decode; bits at or above MASK_W are never set.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (i < MASK_W) begin : g_live
            assign port_mask[i] = (port_idx == PORT_W'(i));
        end else begin : g_dead
            assign port_mask[i] = 1'b0;
        end
    end

endmodule

// File: rtl/stsi_tpid_detect.sv
module stsi_tpid_detect #(
    parameter logic [7:0] TPID_HI = 8'h81,
    parameter logic [7:0] TPID_LO = 8'h00
) (
    input  logic [7:0] byte_hi,
    input  logic [7:0] byte_lo,
    output logic       is_vlan
);

    always_comb begin
        is_vlan = (byte_hi == TPID_HI) && (byte_lo == TPID_LO);
    end

endmodule

// File: rtl/stsi_seq.sv
module stsi_seq
    import stsi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [STSI_BYTE_W-1:0] s_tdata,
    input  logic                   s_tvalid,
    input  logic                   s_tlast,
    output logic                   s_tready,
    input  logic [STSI_BYTE_W-1:0] port_mask,
    input  logic                   hint_in,
    input  logic                   vlan_match,
    output logic [STSI_BYTE_W-1:0] held_hi,
    output logic [STSI_BYTE_W-1:0] m_tdata,
    output logic                   m_tvalid,
    input  logic                   m_tready,
    output logic                   m_tlast,
    output logic                   hint_err
);

    localparam logic [STSI_CNT_W-1:0] LAST_ADDR = STSI_CNT_W'(STSI_ADDR_LEN - 1);

    seq_regs_t r_d, r_q;
    logic      adv;
    logic      take;

    always_comb begin
        r_d      = r_q;
        r_d.herr = 1'b0;
        adv      = !r_q.ovalid || m_tready;
        s_tready = adv && (r_q.st inside {S_ADDR, S_HOLD0, S_HOLD1, S_BODY});
        take     = s_tready && s_tvalid;

        if (adv) begin
            r_d.ovalid = 1'b0;
            r_d.olast  = 1'b0;
            case (r_q.st)
                S_ADDR: begin
                    if (take) begin
                        r_d.ovalid = 1'b1;
                        r_d.odata  = s_tdata;
                        r_d.olast  = s_tlast;
                        if (r_q.cnt == '0) begin
                            r_d.mask = port_mask;
                            r_d.hint = hint_in;
                        end
                        if (s_tlast) begin
                            r_d.cnt = '0;
                        end else if (r_q.cnt == LAST_ADDR) begin
                            r_d.cnt = '0;
                            r_d.st  = S_HOLD0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                S_HOLD0: begin
                    if (take) begin
                        r_d.hold_hi = s_tdata;
                        if (s_tlast) begin
                            r_d.ovalid = 1'b1;
                            r_d.odata  = s_tdata;
                            r_d.olast  = 1'b1;
                            r_d.st     = S_ADDR;
                        end else begin
                            r_d.st = S_HOLD1;
                        end
                    end
                end
                S_HOLD1: begin
                    if (take) begin
                        r_d.hold_lo   = s_tdata;
                        r_d.hold_last = s_tlast;
                        r_d.is_vlan   = vlan_match;
                        r_d.herr      = (r_q.hint != vlan_match);
                        r_d.st        = S_TAG0;
                    end
                end
                S_TAG0: begin
                    r_d.ovalid = 1'b1;
                    r_d.odata  = {{(STSI_BYTE_W-1){1'b0}}, r_q.is_vlan};
                    r_d.st     = S_TAG1;
                end
                S_TAG1: begin
                    r_d.ovalid = 1'b1;
                    r_d.odata  = r_q.mask;
                    if (r_q.is_vlan) begin
                        r_d.olast = r_q.hold_last;
                        r_d.st    = r_q.hold_last ? S_ADDR : S_BODY;
                    end else begin
                        r_d.st = S_TAG2;
                    end
                end
                S_TAG2: begin
                    r_d.ovalid = 1'b1;
                    r_d.odata  = '0;
                    r_d.st     = S_TAG3;
                end
                S_TAG3: begin
                    r_d.ovalid = 1'b1;
                    r_d.odata  = '0;
                    r_d.st     = S_ET0;
                end
                S_ET0: begin
                    r_d.ovalid = 1'b1;
                    r_d.odata  = r_q.hold_hi;
                    r_d.st     = S_ET1;
                end
                S_ET1: begin
                    r_d.ovalid = 1'b1;
                    r_d.odata  = r_q.hold_lo;
                    r_d.olast  = r_q.hold_last;
                    r_d.st     = r_q.hold_last ? S_ADDR : S_BODY;
                end
                S_BODY: begin
                    if (take) begin
                        r_d.ovalid = 1'b1;
                        r_d.odata  = s_tdata;
                        r_d.olast  = s_tlast;
                        if (s_tlast) begin
                            r_d.st = S_ADDR;
                        end
                    end
                end
                default: begin
                    r_d.st  = S_ADDR;
                    r_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign held_hi  = r_q.hold_hi;
    assign m_tdata  = r_q.odata;
    assign m_tvalid = r_q.ovalid;
    assign m_tlast  = r_q.olast;
    assign hint_err = r_q.herr;

endmodule

// File: rtl/stsi_tag_inserter.sv
module stsi_tag_inserter
    import stsi_pkg::*;
#(
    parameter int unsigned PORT_W  = 3,
    parameter int unsigned MASK_W  = 6,
    parameter logic [7:0]  TPID_HI = 8'h81,
    parameter logic [7:0]  TPID_LO = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tlast,
    input  logic [PORT_W-1:0] dst_port,
    input  logic              vlan_hint,
    output logic [7:0]        m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    output logic              hint_err
);

    logic [STSI_BYTE_W-1:0] port_mask;
    logic [STSI_BYTE_W-1:0] held_hi;
    logic                   vlan_match;

    stsi_portmask #(
        .PORT_W (PORT_W),
        .MASK_W (MASK_W),
        .BYTE_W (STSI_BYTE_W)
    ) u_mask (
        .port_idx  (dst_port),
        .port_mask (port_mask)
    );

    stsi_tpid_detect #(
        .TPID_HI (TPID_HI),
        .TPID_LO (TPID_LO)
    ) u_detect (
        .byte_hi (held_hi),
        .byte_lo (s_tdata),
        .is_vlan (vlan_match)
    );

    stsi_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_tdata    (s_tdata),
        .s_tvalid   (s_tvalid),
        .s_tlast    (s_tlast),
        .s_tready   (s_tready),
        .port_mask  (port_mask),
        .hint_in    (vlan_hint),
        .vlan_match (vlan_match),
        .held_hi    (held_hi),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tlast    (m_tlast),
        .hint_err   (hint_err)
    );

endmodule

// File: rtl/stsi_checker.sv
module stsi_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       s_tvalid,
    input logic       s_tready,
    input logic [7:0] m_tdata,
    input logic       m_tvalid,
    input logic       m_tready,
    input logic       m_tlast,
    input logic       hint_err
);

    // R8: a stalled output beat stays put
    a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R8: no input is taken while the output is stalled
    a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |-> !s_tready);

    // R5: the mismatch flag is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hint_err |=> !hint_err);

    // R5: the mismatch flag always follows an accepted input byte
    a_r5_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        hint_err |-> $past(s_tvalid && s_tready));

endmodule

bind stsi_tag_inserter stsi_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .hint_err (hint_err)
);

// File: tb/stsi_tag_inserter_test.sv
`timescale 1ns/1ps
module stsi_tag_inserter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_tdata = '0;
    logic       s_tvalid = 1'b0;
    logic       s_tready;
    logic       s_tlast = 1'b0;
    logic [2:0] dst_port = '0;
    logic       vlan_hint = 1'b0;
    logic [7:0] m_tdata;
    logic       m_tvalid;
    logic       m_tready = 1'b0;
    logic       m_tlast;
    logic       hint_err;

    always #5 clk = ~clk;

    stsi_tag_inserter uut (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tlast(s_tlast), .dst_port(dst_port),
        .vlan_hint(vlan_hint), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast), .hint_err(hint_err)
    );

    // Vector fields: [12:10] port, [9] hint, [8] tagged, [7:0] length
    localparam int NVEC = 8;
    localparam logic [12:0] VEC [NVEC] = '{
        {3'd2, 1'b0, 1'b0, 8'd20},
        {3'd5, 1'b1, 1'b1, 8'd22},
        {3'd0, 1'b1, 1'b0, 8'd14},
        {3'd6, 1'b0, 1'b1, 8'd18},
        {3'd3, 1'b0, 1'b0, 8'd64},
        {3'd1, 1'b1, 1'b1, 8'd14},
        {3'd4, 1'b0, 1'b0, 8'd9},
        {3'd7, 1'b0, 1'b0, 8'd13}
    };

    int checks = 0;
    int fails  = 0;

    logic [7:0] in_d [1024];
    logic       in_l [1024];
    logic [2:0] in_p [1024];
    logic       in_h [1024];
    int         in_n = 0;
    logic [7:0] exp_d [1024];
    logic       exp_l [1024];
    int         exp_n = 0;
    int         fr_s [NVEC];
    int         fr_c [NVEC];
    int         fr_k [NVEC];
    logic [7:0] got_d [1100];
    logic       got_l [1100];
    int         got_n;
    int         exp_stalls = 0;
    int         exp_mism = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic l);
        exp_d[exp_n] = b;
        exp_l[exp_n] = l;
        exp_n++;
    endtask

    task automatic build();
        for (int fi = 0; fi < NVEC; fi++) begin
            logic [2:0] p;
            logic       h, tg;
            int         len, base;
            logic [7:0] mask;
            p    = VEC[fi][12:10];
            h    = VEC[fi][9];
            tg   = VEC[fi][8];
            len  = int'(VEC[fi][7:0]);
            base = in_n;
            mask = (p < 3'd6) ? (8'd1 << p) : 8'h00;
            for (int i = 0; i < len; i++) begin
                logic [7:0] b;
                if (i == 12)      b = tg ? 8'h81 : 8'h08;
                else if (i == 13) b = tg ? 8'h00 : 8'h06;
                else              b = 8'(fi * 37 + i * 3 + 5);
                in_d[in_n] = b;
                in_l[in_n] = (i == len - 1);
                in_p[in_n] = p;
                in_h[in_n] = h;
                in_n++;
            end
            fr_s[fi] = exp_n;
            if (len < 14) begin
                fr_k[fi] = 10;
                for (int i = 0; i < len; i++) push(in_d[base + i], i == len - 1);
            end else begin
                fr_k[fi] = tg ? 2 : 3;
                exp_stalls += tg ? 2 : 6;
                if (h != tg) exp_mism++;
                for (int i = 0; i < 12; i++) push(in_d[base + i], 1'b0);
                if (tg) begin
                    push(8'h01, 1'b0);
                    push(mask, len == 14);
                    for (int i = 14; i < len; i++) push(in_d[base + i], i == len - 1);
                end else begin
                    push(8'h00, 1'b0);
                    push(mask, 1'b0);
                    push(8'h00, 1'b0);
                    push(8'h00, 1'b0);
                    for (int i = 12; i < len; i++) push(in_d[base + i], i == len - 1);
                end
            end
            fr_c[fi] = exp_n - fr_s[fi];
        end
    endtask

    task automatic run_stream(input int mode);
        int ip, cyc, stalls, first_acc, last_acc, hold_viol, herr_cnt;
        logic [15:0] lfsr;
        logic prev_stall, prev_l, vld;
        logic [7:0] prev_d;
        ip = 0; cyc = 0; stalls = 0; first_acc = -1; last_acc = 0;
        hold_viol = 0; herr_cnt = 0; got_n = 0;
        lfsr = 16'hACE1; prev_stall = 1'b0; prev_l = 1'b0; prev_d = '0;
        while ((ip < in_n || got_n < exp_n) && cyc < 20000) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            vld = (mode == 1) ? 1'b1 : (lfsr[0] | lfsr[3]);
            s_tvalid  = (ip < in_n) && vld;
            s_tdata   = (ip < in_n) ? in_d[ip] : 8'h00;
            s_tlast   = (ip < in_n) ? in_l[ip] : 1'b0;
            dst_port  = (ip < in_n) ? in_p[ip] : 3'd0;
            vlan_hint = (ip < in_n) ? in_h[ip] : 1'b0;
            m_tready  = (mode == 1) ? 1'b1 : (lfsr[5] | lfsr[7]);
            #1;
            if (prev_stall && !(m_tvalid && m_tdata == prev_d && m_tlast == prev_l)) hold_viol++;
            if (m_tvalid && !m_tready && s_tready) hold_viol++;
            prev_stall = m_tvalid && !m_tready;
            prev_d = m_tdata;
            prev_l = m_tlast;
            if (hint_err) herr_cnt++;
            if (s_tvalid && !s_tready) stalls++;
            if (s_tvalid && s_tready) begin
                if (first_acc < 0) first_acc = cyc;
                last_acc = cyc;
                ip++;
            end
            if (m_tvalid && m_tready && got_n < 1100) begin
                got_d[got_n] = m_tdata;
                got_l[got_n] = m_tlast;
                got_n++;
            end
            cyc++;
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        chk(cyc < 20000, "watchdog of stream run", cyc, 20000);
        chk(got_n == exp_n, "R2 R3 output byte count", got_n, exp_n);
        for (int fi = 0; fi < NVEC; fi++) begin
            int bad;
            bad = -1;
            for (int k = 0; k < fr_c[fi]; k++) begin
                int g;
                g = fr_s[fi] + k;
                if (bad < 0 && (g >= got_n || got_d[g] !== exp_d[g] || got_l[g] !== exp_l[g]))
                    bad = k;
            end
            if (fr_k[fi] == 10)
                chk(bad < 0, "R10 R7 short frame pass-through, first bad byte", bad, -1);
            else if (fr_k[fi] == 2)
                chk(bad < 0, "R1 R2 R4 R7 tagged frame, first bad byte", bad, -1);
            else
                chk(bad < 0, "R1 R3 R4 R7 untagged frame, first bad byte", bad, -1);
        end
        chk(herr_cnt == exp_mism, "R5 hint mismatch pulses", herr_cnt, exp_mism);
        if (mode == 0) begin
            chk(hold_viol == 0, "R8 stalled output held and input blocked", hold_viol, 0);
        end else begin
            chk(stalls == exp_stalls, "R6 input stall cycles at full rate", stalls, exp_stalls);
            chk(last_acc - first_acc + 1 == in_n + exp_stalls,
                "R9 back-to-back frame acceptance span", last_acc - first_acc + 1, in_n + exp_stalls);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        build();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!m_tvalid && !hint_err, "R11 outputs idle in reset", int'(m_tvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(s_tready && !m_tvalid, "R11 ready after reset", int'(s_tready), 1);
        run_stream(0);
        repeat (4) @(negedge clk);
        run_stream(1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule